// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. It receives control fields as plain levels: a channel code, a resolution select, a continuous-run enable, a hardware-start enable and a clock-divide select. It also receives a one-cycle strobe that marks a write of those fields.

A conversion starts from a software write or from a rising edge on an asynchronous trigger pin. The block then drives a trial code to an external comparator, one bit per divided clock, most significant bit first. It keeps or drops each bit from the comparator's answer. When the last bit is resolved it latches the result and raises a completion flag. In continuous mode the next conversion starts in the same cycle as the latch, so conversions run back to back until a write of the reserved all-ones channel code stops them. The sampling circuit and the comparator are outside the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and directly after it, `busy` and `done` are 0 and `result` is 0.
- R2: A `sc_wr` pulse while `hwtrig_en` is 0 and `chan_sel` is not all ones starts a conversion. `busy` is 1 after that clock edge.
- R3: `div_sel` values 0, 1, 2 and 3 give a step period of 1, 2, 4 and 8 clocks. A 10-bit conversion latches `result`, sets `done` and drops `busy` exactly 10 step periods after its start edge. This holds when not in continuous mode.
- R4: The comparator input `cmp_in` is 1 when the analog level is at or above `dac_code`. With an ideal comparator, a 10-bit result is the largest code not above the analog level. The full-scale and zero inputs are included.
- R5: With `res8` = 1 when the conversion starts, the conversion takes 8 step periods. `dac_code` carries the 8-bit trial shifted left by 2. `result` is right-justified with bits 9:8 zero.
- R6: With `hwtrig_en` = 1, a `sc_wr` starts nothing. A rising edge on `hw_trig` starts a conversion: `busy` rises at the third clock edge after the pin rises, because of a two-flop synchronizer and edge detector.
- R7: A rising edge of `hw_trig` that is detected while `busy` is 1 is ignored. No second conversion follows the current one.
- R8: With `cont_en` = 1, the clock edge that latches a result also starts the next conversion, and `busy` stays 1. When the stream was started by hardware, later trigger edges do not change its timing.
- R9: A `sc_wr` with `chan_sel` all ones (5'b11111) aborts any conversion or stream. `busy` is 0 after that edge and no result is latched. While `chan_sel` is all ones, hardware edges start nothing.
- R10: `done` is cleared by a `res_rd` pulse or by any `sc_wr`. A result latched in the same cycle as `res_rd` leaves `done` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 5 | Channel code; all ones means off |
| res8 | input | 1 | 1 selects 8-bit, 0 selects 10-bit conversion |
| cont_en | input | 1 | Continuous conversion enable |
| hwtrig_en | input | 1 | Hardware start enable |
| div_sel | input | 2 | Step clock divide select (1, 2, 4, 8) |
| sc_wr | input | 1 | Write strobe of the control fields |
| res_rd | input | 1 | Result read strobe |
| hw_trig | input | 1 | Asynchronous hardware start pin |
| cmp_in | input | 1 | Comparator decision from the analog side |
| dac_code | output | 10 | Trial code driven to the analog side |
| result | output | 10 | Latched conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion complete flag |

## Verification
Any fault in the bit pointer, the divider count or the kept trial bits shows up in `result` when the conversion ends. The time it takes is at most 80 clocks. A wrong step count or divide value moves the fall of `busy` and the rise of `done` by whole step periods. These are compared on every clock. A synchronizer or edge-detect fault in the trigger path, or a missed busy gate, shows as a start that comes a cycle early or late, or as a conversion that should not happen. It appears within three clocks of the trigger edge, or one conversion time later.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  parameter int CH_W  = 5,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             res8,
  input  logic             cont_en,
  input  logic             hwtrig_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             sc_wr,
  input  logic             res_rd,
  input  logic             hw_trig,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             done
);

  localparam int DCNT_W = (1 << DIV_W) - 1;
  localparam int PTR_W  = $clog2(RES_W);
  localparam int SH     = RES_W - LO_W;

  logic [1:0]        sync;
  logic              trig_q;
  logic              mode8;
  logic [PTR_W-1:0]  ptr;
  logic [RES_W-1:0]  sar;
  logic [DCNT_W-1:0] dcnt;

  logic [DCNT_W-1:0] dlim;
  logic [RES_W-1:0]  bit_mask, res_next;
  logic              ch_off, trig_rise, tick, last, step;
  logic              sw_start, hw_start, restart, start;

  assign ch_off    = &chan_sel;
  assign trig_rise = sync[1] & ~trig_q;
  assign dlim      = DCNT_W'((1 << div_sel) - 1);
  assign tick      = busy & (dcnt == dlim);
  assign step      = tick & ~sc_wr;
  assign last      = step & (ptr == '0);

  assign bit_mask  = RES_W'(1) << ptr;
  assign res_next  = cmp_in ? (sar | bit_mask) : (sar & ~bit_mask);

  assign sw_start  = sc_wr & ~ch_off & ~hwtrig_en;
  assign hw_start  = trig_rise & hwtrig_en & ~busy & ~sc_wr & ~ch_off;
  assign restart   = last & cont_en;
  assign start     = sw_start | hw_start | restart;

  assign dac_code  = mode8 ? (sar << SH) : sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= '0;
      trig_q <= 1'b0;
    end else begin
      sync   <= {sync[0], hw_trig};
      trig_q <= sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (start || tick) begin
      dcnt <= '0;
    end else if (busy) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mode8  <= 1'b0;
      ptr    <= '0;
      sar    <= '0;
      result <= '0;
    end else begin
      if (res_rd) done <= 1'b0;
      if (step) begin
        sar <= res_next | (bit_mask >> 1);
        if (last) begin
          result <= res_next;
          done   <= 1'b1;
          busy   <= 1'b0;
        end else begin
          ptr <= ptr - 1'b1;
        end
      end
      if (sc_wr) begin
        busy <= 1'b0;
        done <= 1'b0;
      end
      if (start) begin
        busy  <= 1'b1;
        mode8 <= res8;
        ptr   <= res8 ? PTR_W'(LO_W - 1) : PTR_W'(RES_W - 1);
        sar   <= res8 ? (RES_W'(1) << (LO_W - 1)) : (RES_W'(1) << (RES_W - 1));
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  parameter int CH_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CH_W-1:0]  chan_sel,
  input logic             hwtrig_en,
  input logic             cont_en,
  input logic             sc_wr,
  input logic             busy,
  input logic             done,
  input logic             mode8,
  input logic [RES_W-1:0] result
);

  AST_SW_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr && !(&chan_sel) && !hwtrig_en |=> busy); // R2

  AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(sc_wr) |-> done); // R3

  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && mode8 |-> result[RES_W-1:LO_W] == '0); // R5

  AST_HW_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr && hwtrig_en |=> !busy); // R6

  AST_CONT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cont_en && !sc_wr |=> busy); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr && (&chan_sel) |=> !busy); // R9

  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> !done); // R10

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .LO_W(LO_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .hwtrig_en(hwtrig_en),
  .cont_en(cont_en), .sc_wr(sc_wr), .busy(busy), .done(done),
  .mode8(mode8), .result(result)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] chan_sel = 5'd0;
  logic       res8 = 1'b0, cont_en = 1'b0, hwtrig_en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       sc_wr = 1'b0, res_rd = 1'b0, hw_trig = 1'b0;
  logic       cmp_in;
  logic [9:0] dac_code, result;
  logic       busy, done;
  int         vin = 0;
  int         vectors = 0, fails = 0;

  always #10 clk = ~clk;

  assign cmp_in = (vin >= int'(dac_code));

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .res8(res8),
    .cont_en(cont_en), .hwtrig_en(hwtrig_en), .div_sel(div_sel),
    .sc_wr(sc_wr), .res_rd(res_rd), .hw_trig(hw_trig), .cmp_in(cmp_in),
    .dac_code(dac_code), .result(result), .busy(busy), .done(done)
  );

  int m_busy, m_done, m_res, m_left, m_mode8, m_s0, m_s1, m_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_res = 0; m_left = 0; m_mode8 = 0;
      m_s0 = 0; m_s1 = 0; m_q = 0;
    end else begin
      int  ob;
      bit  rise, off, fin, st;
      ob   = m_busy;
      rise = (m_s1 == 1) && (m_q == 0);
      m_q  = m_s1; m_s1 = m_s0; m_s0 = int'(hw_trig);
      off  = (chan_sel == 5'h1f);
      fin  = (ob == 1) && (m_left == 1) && !sc_wr;
      if (res_rd) m_done = 0;
      if (ob == 1 && !sc_wr) begin
        if (fin) begin
          m_res = (m_mode8 == 1) ? vin / 4 : vin;
          m_done = 1; m_busy = 0;
        end else m_left--;
      end
      if (sc_wr) begin m_busy = 0; m_done = 0; end
      st = (sc_wr && !off && !hwtrig_en) ||
           (rise && hwtrig_en && ob == 0 && !sc_wr && !off) ||
           (fin && cont_en);
      if (st) begin
        m_busy = 1; m_mode8 = int'(res8);
        m_left = (res8 ? 8 : 10) * (1 << div_sel);
      end
    end
  end

  task automatic run(int n, string req);
    repeat (n) begin
      @(negedge clk);
      vectors++;
      if (int'(busy) != m_busy || int'(done) != m_done || int'(result) != m_res) begin
        fails++;
        $display("FAIL %s t=%0t busy/done/result actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 req, $time, busy, done, result, m_busy, m_done, m_res);
      end
    end
  endtask

  task automatic wr(logic [4:0] c, string req);
    chan_sel = c; sc_wr = 1'b1;
    run(1, req);
    sc_wr = 1'b0;
  endtask

  task automatic pulse(int hold, string req);
    hw_trig = 1'b1; run(hold, req);
    hw_trig = 1'b0; run(1, req);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    run(3, "R1");
    rst_n = 1'b1;
    run(2, "R1");
    vin = 613; div_sel = 2'd0;                 // R2 R3 R4
    wr(5'd3, "R2"); run(14, "R3");
    vin = 1023; div_sel = 2'd3;
    wr(5'd3, "R4"); run(84, "R4");
    vin = 517; div_sel = 2'd1; res8 = 1'b1;    // R5
    wr(5'd1, "R5"); run(20, "R5");
    res8 = 1'b0;
    res_rd = 1'b1; run(1, "R10"); res_rd = 1'b0; run(2, "R10");
    vin = 0; div_sel = 2'd2;
    wr(5'd7, "R4"); run(44, "R4");
    vin = 341;
    wr(5'd7, "R3"); run(10, "R3");
    res_rd = 1'b1; run(1, "R10"); res_rd = 1'b0;   // read mid-conversion
    run(34, "R3");
    hwtrig_en = 1'b1; vin = 800; div_sel = 2'd0;   // R6
    wr(5'd2, "R6"); run(5, "R6");
    pulse(3, "R6"); run(5, "R6");
    pulse(2, "R7"); run(20, "R7");                 // R7 edge while busy
    hwtrig_en = 1'b0; cont_en = 1'b1; vin = 200;   // R8 software stream
    wr(5'd4, "R8"); run(35, "R8");
    wr(5'h1f, "R9"); run(15, "R9");
    hwtrig_en = 1'b1; vin = 455; div_sel = 2'd1;   // R8 hardware stream
    wr(5'd2, "R8"); run(2, "R8");
    pulse(2, "R8"); run(12, "R8");
    pulse(2, "R8"); run(40, "R8");
    wr(5'h1f, "R9"); run(4, "R9");
    pulse(2, "R9"); run(20, "R9");                 // R9 edges ignored when off
    hwtrig_en = 1'b0; cont_en = 1'b0; div_sel = 2'd0;
    wr(5'd4, "R9"); run(5, "R9");
    wr(5'h1f, "R9"); run(15, "R9");                // R9 abort mid-conversion
    wr(5'd4, "R10"); run(12, "R10");
    wr(5'h1f, "R10"); run(3, "R10");               // R10 write clears done
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule